// File: doc/BRIEF.md
# Systolic Convolution Array with Selectable Weight Banks

This block filters a stream of signed samples with a three-tap convolution built as a linear systolic array. One cell serves each tap. Every cell keeps its own small store of coefficients and has two arithmetic stages: a product register and a running-sum register. A sample enters the first cell and moves one cell per clock. Partial sums move in the same direction at half that speed, through two registers per cell. Because of this rate difference, each partial sum meets the next newer sample at each cell it visits. Each sample is therefore reused by every cell without being read again, and all wiring runs between neighbouring cells only.

Each cell holds four coefficient sets. The caller tags every sample with a 2-bit bank number when the sample enters. The sample carries that tag with it through the array, so a bank change mid-stream affects only samples that arrive after the change. Results already in flight keep the coefficients of their own samples. Coefficients are loaded through a simple write port that names the tap and the bank. A finished result leaves the last cell with a valid flag once three consecutive valid samples have passed through the pipeline.

Top module: `sysconv_array`

## Requirements
- R1: For a window of samples s0, s1, s2 that enter on three consecutive clocks, the result is w0*s0 + w1*s1 + w2*s2, where tap 0 is paired with the oldest sample and tap 2 with the newest. Samples and coefficients are 16-bit two's complement.
- R2: The coefficient applied to a sample comes from the bank given by `in_bank` (0 to 3) on the clock when that sample enters. A window whose samples carry different banks mixes the banks per sample, and a bank change never alters a result already in flight.
- R3: `out_valid` is high only for a window whose three samples all entered with `in_valid` high on consecutive clocks. A cycle without a valid sample suppresses every window that contains it, and no result appears before three valid samples have entered since reset.
- R4: A window's result is visible after the fourth rising edge, counting the edge that samples the window's last sample. Exactly one result is produced per window.
- R5: The result is a 36-bit two's complement value that is exact over the full input range. All-minimum samples with all-minimum coefficients give +3221225472. Samples of 32767 with coefficients of -32768 give -3221127168.
- R6: A synchronous active-high reset clears `out_valid` and every stage of the pipeline, discards results in flight, and sets every coefficient in every bank to zero.
- R7: With `wr_en` high at a rising edge, coefficient (`wr_tap`, `wr_bank`) takes `wr_weight`, and products formed after that edge use it. A write with `wr_tap` equal to 3, which names no tap, changes no coefficient.
- R8: The array accepts one sample per clock. N consecutive valid samples yield N-2 results on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is presented this clock |
| in_bank | input | 2 | Coefficient bank tag for the sample entering this clock |
| in_sample | input | 16 | Signed input sample |
| wr_en | input | 1 | Coefficient write strobe |
| wr_tap | input | 2 | Tap index of the coefficient written (0 to 2) |
| wr_bank | input | 2 | Bank of the coefficient written |
| wr_weight | input | 16 | Signed coefficient value to store |
| out_valid | output | 1 | A convolution result is present |
| out_result | output | 36 | Signed convolution result |

## Verification
The convolution is first driven with short three-sample windows taken from a fixed vector table. Each table entry targets one bank, so a wrong tap order, bank decode or sign extension shows up as a wrong sum; the entries at the extremes of the range catch a truncated accumulator. A four-sample stream whose bank tag changes between samples separates per-sample bank tagging from per-window or per-cell selection. A gapped valid pattern shows whether windows that straddle a hole are suppressed. A long random stream with frequent bank switches, compared cycle by cycle against a software convolution, exercises every alignment of partial sums and samples and the one-result-per-clock rate. A reset in the middle of a stream, followed by new samples, shows whether both the pipeline and the coefficient store are cleared.

// File: rtl/sysconv_pkg.sv
package sysconv_pkg;

    // Datapath widths
    localparam int SMP_W     = 16;
    localparam int WT_W      = 16;
    localparam int ACC_W     = 36;
    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int PROD_W    = SMP_W + WT_W;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [WT_W-1:0]  wt_t;
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic [BANK_W-1:0]       bank_t;

    // A sample travelling through the array, with its bank tag
    typedef struct packed {
        logic  valid;
        bank_t bank;
        smp_t  data;
    } token_t;

    // A product or partial sum travelling through the array
    typedef struct packed {
        logic valid;
        acc_t sum;
    } psum_t;

    // Largest product magnitude: (-2^(SMP_W-1)) * (-2^(WT_W-1))
    localparam acc_t PROD_MAX = acc_t'(64'sd1 <<< (SMP_W + WT_W - 2));

    // Full-precision product, sign-extended to the accumulator width
    function automatic acc_t widen_prod(input smp_t x, input wt_t w);
        logic signed [PROD_W-1:0] p;
        p = x * w;
        return acc_t'(p);
    endfunction

endpackage

// File: rtl/sysconv_wbank.sv
module sysconv_wbank
    import sysconv_pkg::*;
#(
    parameter int DEPTH = NUM_BANKS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  bank_t wr_sel,
    input  wt_t   wr_val,
    input  bank_t rd_sel,
    output wt_t   rd_val
);

    wt_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_sel] <= wr_val;
        end
    end

    // Coefficient picked by the bank tag of the sample at this cell
    assign rd_val = mem_q[rd_sel];

endmodule

// File: rtl/sysconv_cell.sv
module sysconv_cell
    import sysconv_pkg::*;
#(
    parameter bit TAIL = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  token_t tok_i,
    input  psum_t  ps_i,
    input  logic   wr_en,
    input  bank_t  wr_sel,
    input  wt_t    wr_val,
    output psum_t  ps_o
);

    wt_t   coef;
    psum_t prod_q;
    psum_t sum_q;

    sysconv_wbank #(.DEPTH(NUM_BANKS)) bank_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_val (wr_val),
        .rd_sel (tok_i.bank),
        .rd_val (coef)
    );

    // Multiplier stage
    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
        end else begin
            prod_q.valid <= tok_i.valid;
            prod_q.sum   <= widen_prod(tok_i.data, coef);
        end
    end

    // Adder stage: works on the previous product while a new one forms
    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else begin
            sum_q.valid <= ps_i.valid & prod_q.valid;
            sum_q.sum   <= ps_i.sum + prod_q.sum;
        end
    end

    // Partial sums take two registers per cell except at the tail
    if (TAIL) begin : g_tail
        assign ps_o = sum_q;
    end else begin : g_hold
        psum_t hold_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q <= '0;
            end else begin
                hold_q <= sum_q;
            end
        end
        assign ps_o = hold_q;
    end

    // R5
    prod_bound_chk: assert property (@(posedge clk) disable iff (rst)
        prod_q.valid |-> ($signed(prod_q.sum) <= PROD_MAX &&
                          $signed(prod_q.sum) >= -PROD_MAX));

    // R4
    mul_add_order_chk: assert property (@(posedge clk) disable iff (rst)
        sum_q.valid |-> $past(tok_i.valid, 2));

endmodule

// File: rtl/sysconv_array.sv
module sysconv_array
    import sysconv_pkg::*;
#(
    parameter int TAPS = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [BANK_W-1:0]        in_bank,
    input  logic signed [SMP_W-1:0]  in_sample,
    input  logic                     wr_en,
    input  logic [$clog2(TAPS)-1:0]  wr_tap,
    input  logic [BANK_W-1:0]        wr_bank,
    input  logic signed [WT_W-1:0]   wr_weight,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_result
);

    localparam int   TAP_W   = $clog2(TAPS);
    localparam int   CNT_W   = $clog2(TAPS + 1);
    localparam acc_t SUM_MAX = PROD_MAX * TAPS;

    token_t head_tok;
    token_t tok_q   [TAPS-1];
    psum_t  ps_chain[TAPS];
    psum_t  ps_seed;

    assign head_tok = '{valid: in_valid, bank: in_bank, data: in_sample};
    assign ps_seed  = '{valid: 1'b1, sum: '0};

    // Sample path: one register between neighbouring cells
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < TAPS - 1; j++) begin
                tok_q[j] <= '0;
            end
        end else begin
            tok_q[0] <= head_tok;
            for (int j = 1; j < TAPS - 1; j++) begin
                tok_q[j] <= tok_q[j-1];
            end
        end
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_cell
        token_t tk_in;
        psum_t  ps_in;
        logic   we;

        if (k == 0) begin : g_head
            assign tk_in = head_tok;
            assign ps_in = ps_seed;
        end else begin : g_body
            assign tk_in = tok_q[k-1];
            assign ps_in = ps_chain[k-1];
        end

        assign we = wr_en && (wr_tap == TAP_W'(k));

        sysconv_cell #(.TAIL(k == TAPS - 1)) cell_i (
            .clk    (clk),
            .rst    (rst),
            .tok_i  (tk_in),
            .ps_i   (ps_in),
            .wr_en  (we),
            .wr_sel (wr_bank),
            .wr_val (wr_weight),
            .ps_o   (ps_chain[k])
        );
    end

    assign out_valid  = ps_chain[TAPS-1].valid;
    assign out_result = ps_chain[TAPS-1].sum;

    // Valid samples accepted since reset, saturating at the tap count
    logic [CNT_W-1:0] vin_cnt_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            vin_cnt_q <= '0;
        end else if (in_valid && vin_cnt_q != CNT_W'(TAPS)) begin
            vin_cnt_q <= vin_cnt_q + 1'b1;
        end
    end

    // R3
    fill_before_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (vin_cnt_q == CNT_W'(TAPS)));

    // R5
    sum_bound_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_result <= SUM_MAX && out_result >= -SUM_MAX));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/sysconv_array_tb_top.sv
module sysconv_array_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NTAPS      = 3;
    localparam int HMAX       = 4096;
    localparam int WIN_LAG    = 5;   // record index minus window start

    typedef struct packed {
        logic [1:0]          bank;
        logic signed [15:0]  s0;
        logic signed [15:0]  s1;
        logic signed [15:0]  s2;
        logic signed [39:0]  expv;
    } vec_t;

    // Coefficients loaded per bank: BW[bank][tap]
    localparam int BW [4][3] = '{
        '{1, 2, 3},
        '{-1, 0, 4},
        '{100, -200, 300},
        '{-32768, -32768, -32768}
    };

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 16'sd10,    16'sd20,    16'sd30,    40'sd140},
        '{2'd1, 16'sd5,     -16'sd7,    16'sd9,     40'sd31},
        '{2'd2, 16'sd1,     16'sd2,     16'sd3,     40'sd600},
        '{2'd3, 16'sh8000,  16'sh8000,  16'sh8000,  40'sd3221225472},
        '{2'd3, 16'sd32767, 16'sd32767, 16'sd32767, -40'sd3221127168},
        '{2'd0, -16'sd1,    -16'sd1,    -16'sd1,    -40'sd6},
        '{2'd2, 16'sd0,     16'sd0,     16'sd7,     40'sd2100},
        '{2'd1, 16'sd1000,  16'sd1000,  16'sd1000,  40'sd3000}
    };

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic [1:0]         in_bank;
    logic signed [15:0] in_sample;
    logic               wr_en;
    logic [1:0]         wr_tap;
    logic [1:0]         wr_bank;
    logic signed [15:0] wr_weight;
    logic               out_valid;
    logic signed [35:0] out_result;

    int    checks = 0;
    int    errors = 0;
    int    n = 0;
    int    out_cnt = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    bit hist_v [HMAX];
    int hist_x [HMAX];
    int hist_b [HMAX];
    int wm [NTAPS][4];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sysconv_array #(.TAPS(NTAPS)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_bank    (in_bank),
        .in_sample  (in_sample),
        .wr_en      (wr_en),
        .wr_tap     (wr_tap),
        .wr_bank    (wr_bank),
        .wr_weight  (wr_weight),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)",
                     tag, what, act, expv, $time);
        end
    endtask

    // One clock: record what the last edge sampled, compare the output
    task automatic step();
        int     i;
        bit     ev;
        longint es;
        @(negedge clk);
        hist_v[n] = in_valid;
        hist_x[n] = int'(in_sample);
        hist_b[n] = int'(in_bank);
        i  = n - WIN_LAG;
        ev = (i >= 0) && hist_v[i] && hist_v[i+1] && hist_v[i+2];
        es = 0;
        if (ev) begin
            for (int k = 0; k < NTAPS; k++) begin
                es += longint'(wm[k][hist_b[i+k]]) * longint'(hist_x[i+k]);
            end
        end
        check(out_valid === ev, cur_tag, "out_valid", longint'(out_valid), longint'(ev));
        if (ev) begin
            check(longint'(out_result) == es, cur_tag, "out_result",
                  longint'(out_result), es);
        end
        if (out_valid === 1'b1) out_cnt++;
        if (wr_en && wr_tap < NTAPS) wm[wr_tap][wr_bank] = int'(wr_weight);
        n++;
    endtask

    task automatic idle(input int cycles);
        in_valid = 1'b0;
        wr_en    = 1'b0;
        for (int c = 0; c < cycles; c++) step();
    endtask

    task automatic push(input int x, input int b);
        in_valid  = 1'b1;
        in_sample = 16'(x);
        in_bank   = 2'(b);
        step();
    endtask

    task automatic load_w(input int t, input int b, input int w);
        in_valid  = 1'b0;
        wr_en     = 1'b1;
        wr_tap    = 2'(t);
        wr_bank   = 2'(b);
        wr_weight = 16'(w);
        step();
        wr_en     = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        wr_en    = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        n       = 0;
        out_cnt = 0;
        for (int t = 0; t < NTAPS; t++)
            for (int b = 0; b < 4; b++) wm[t][b] = 0;
    endtask

    // Three samples, then read the result four edges after the last one
    task automatic run_vec(input vec_t v, input string tag);
        idle(6);
        cur_tag = tag;
        push(int'(v.s0), int'(v.bank));
        push(int'(v.s1), int'(v.bank));
        push(int'(v.s2), int'(v.bank));
        idle(3);
        check(out_valid === 1'b1, "R4", "latency valid", longint'(out_valid), 1);
        check(longint'(out_result) == longint'($signed(v.expv)), tag, "table result",
              longint'(out_result), longint'($signed(v.expv)));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        vec_t v;
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_bank   = '0;
        in_sample = '0;
        wr_en     = 1'b0;
        wr_tap    = '0;
        wr_bank   = '0;
        wr_weight = '0;

        // R6: state after reset
        do_reset();
        check(out_valid === 1'b0, "R6", "out_valid after reset", longint'(out_valid), 0);

        // R6: coefficients are zero after reset
        cur_tag = "R6";
        push(9, 2); push(9, 2); push(9, 2);
        idle(3);
        check(out_valid === 1'b1 && out_result == 0, "R6", "zero coefficients",
              longint'(out_result), 0);
        idle(4);

        // Load every bank
        cur_tag = "R7";
        for (int b = 0; b < 4; b++)
            for (int t = 0; t < NTAPS; t++) load_w(t, b, BW[b][t]);

        // R1 / R5: table walk
        for (int j = 0; j < NVEC; j++) begin
            run_vec(VECS[j], (VECS[j].bank == 2'd3) ? "R5" : "R1");
        end

        // R2: bank tag switches inside a window
        idle(6);
        cur_tag = "R2";
        push(1, 0); push(2, 0); push(3, 1); push(4, 1);
        idle(2);
        check(out_valid === 1'b1 && out_result == 17, "R2", "mixed window 0",
              longint'(out_result), 17);
        idle(1);
        check(out_valid === 1'b1 && out_result == 18, "R2", "mixed window 1",
              longint'(out_result), 18);
        idle(4);

        // R7: a write to tap index 3 changes nothing
        cur_tag = "R7";
        load_w(3, 0, 555);
        run_vec(VECS[0], "R7");
        // R7: a real write takes effect
        load_w(2, 0, -3);
        v = '{2'd0, 16'sd10, 16'sd20, 16'sd30, -40'sd40};
        run_vec(v, "R7");
        load_w(2, 0, 3);

        // R3: a gap suppresses every window containing it
        idle(8);
        cur_tag = "R3";
        out_cnt = 0;
        push(11, 0); push(12, 0);
        idle(1);
        push(13, 1); push(14, 1); push(15, 1);
        idle(8);
        check(out_cnt == 1, "R3", "windows around gap", out_cnt, 1);

        // R2 / R8: random stream with random bank switches
        for (int t = 0; t < NTAPS; t++)
            for (int b = 0; b < 4; b++)
                load_w(t, b, int'($urandom_range(0, 65535)) - 32768);
        idle(8);
        cur_tag = "R2";
        out_cnt = 0;
        begin
            int cb;
            cb = 0;
            for (int s = 0; s < 120; s++) begin
                if ($urandom_range(0, 4) == 0) cb = int'($urandom_range(0, 3));
                push(int'($urandom_range(0, 65535)) - 32768, cb);
            end
        end
        idle(8);
        check(out_cnt == 118, "R8", "results from 120 samples", out_cnt, 118);

        // R6: reset in the middle of a stream
        cur_tag = "R6";
        for (int s = 0; s < 6; s++) push(100 + s, s % 4);
        do_reset();
        check(out_valid === 1'b0, "R6", "out_valid after mid-stream reset",
              longint'(out_valid), 0);
        push(5, 0); push(6, 1); push(7, 3);
        idle(3);
        check(out_valid === 1'b1 && out_result == 0, "R6", "coefficients wiped",
              longint'(out_result), 0);
        idle(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule